// File: doc/BRIEF.md
# CAN Receive Slot Acceptance Controller

This block manages a single receive message slot that sits behind a CAN protocol engine. When the engine reports a finished frame, the block combines the frame's qualifiers with the slot's policy field and the result of an external acceptance-filter match. From these it decides whether the frame is taken into the slot. An accepted frame raises a one-cycle load strobe for the payload storage and sets a sticky full flag. The flag blocks every later load until software clears it.

Software sees the slot through one 8-bit control/status byte. A mode input selects between a legacy layout and an enhanced layout. In the legacy layout the policy field is two bits wide and the filter-hit index is three bits wide. In the enhanced layout the policy is a single bit and the index is five bits wide. A frame that passes the policy but finds the slot full produces a one-cycle overflow pulse for the error logic and does not touch the stored status.

Top module: `canrx_slot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and both `load_o` and `ovf_o` are low.
- R2: A frame strobe that passes the active policy while the slot is empty raises `load_o` for exactly one cycle after the strobe edge, and sets the full flag (status bit 7) in that same cycle.
- R3: While the full flag is set, a frame that passes the policy is not loaded. It raises `ovf_o` for one cycle, and status bits 6:0 keep their values.
- R4: The full flag is cleared only by a CPU write with bit 7 = 0. A write with bit 7 = 1 leaves the flag unchanged. When a write that clears the flag and a frame strobe land in the same cycle, the flag value seen by the frame is the value held before that edge.
- R5: In legacy mode (`enh_i` = 0) with policy 2'b11, every frame is accepted: errored frames, frames without a filter hit, and either identifier type.
- R6: In legacy mode with policy 2'b10, only valid extended-identifier frames whose matching filter has its extended-enable bit set are accepted.
- R7: In legacy mode with policy 2'b01, only valid standard-identifier frames whose matching filter has its extended-enable bit clear are accepted.
- R8: In legacy mode with policy 2'b00, a valid frame with a filter hit is accepted when the filter's extended-enable bit equals the frame's identifier type (1 = extended).
- R9: In enhanced mode (`enh_i` = 1), a policy bit of 1 accepts every frame. A policy bit of 0 accepts valid frames with a filter hit. The policy bit is status bit 6.
- R10: The legacy status byte is laid out as follows: bit 7 = full, bits 6:5 = policy, bit 4 = 0, bit 3 = remote-request flag, bits 2:0 = low three bits of the captured filter index. A legacy write loads the policy from bits 6:5.
- R11: The enhanced status byte is laid out as follows: bit 7 = full, bit 6 = policy bit, bit 5 = remote-request flag, bits 4:0 = captured filter index. An enhanced write loads only bit 6, into the upper policy bit. The remote-request flag and the index are never written by the CPU.
- R12: The remote-request flag and the filter index are captured on the same edge that sets the full flag. They hold their values until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_i | input | 1 | Operating mode: 0 legacy, 1 enhanced |
| frm_done_i | input | 1 | One-cycle frame-complete strobe |
| frm_ok_i | input | 1 | Frame received without error |
| frm_ext_i | input | 1 | Frame uses an extended identifier |
| frm_rtr_i | input | 1 | Frame is a remote transmission request |
| flt_hit_i | input | 1 | An acceptance filter matched |
| flt_idx_i | input | 5 | Index of the matching filter |
| flt_ext_en_i | input | 1 | Extended-enable bit of the matching filter |
| reg_wr_i | input | 1 | CPU write strobe for the status byte |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | Status byte in the current mode's layout |
| load_o | output | 1 | One-cycle capture strobe for payload storage |
| ovf_o | output | 1 | One-cycle pulse: passing frame rejected because full |

## Verification
The bench targets frames that arrive while the slot is full, including a clear write in the same cycle. A design that lets the clear win would load the frame instead of pulsing overflow. Each legacy policy is driven with frames whose identifier type disagrees with the filter's extended-enable bit, so an inverted or ignored extended-enable comparison shows up as a wrongly accepted frame. The bench switches the layout while a frame is stored and writes ones into the read-only bit positions. A mis-sliced field, or a writable remote-request or index field, then changes the read-back byte. A write of 1 to the full bit checks that the flag cannot be set from software.

// File: rtl/canrx_slot_pkg.sv
package canrx_slot_pkg;

    localparam int CSR_W     = 8;
    localparam int FIDX_W    = 5;
    localparam int LIDX_W    = 3;
    localparam int POL_W     = 2;

    // bit positions of the status byte that both layouts share
    localparam int FULL_BIT  = 7;
    localparam int POLHI_BIT = 6;
    localparam int POLLO_BIT = 5;

    typedef enum logic [POL_W-1:0] {
        POL_FILTER = 2'b00,
        POL_STD    = 2'b01,
        POL_EXT    = 2'b10,
        POL_ALL    = 2'b11
    } legacy_pol_e;

    typedef struct packed {
        logic              ok;
        logic              ext;
        logic              rtr;
        logic              hit;
        logic              ext_en;
        logic [FIDX_W-1:0] idx;
    } frame_t;

    typedef struct packed {
        logic              full;
        logic [POL_W-1:0]  pol;
        logic              rtr;
        logic [FIDX_W-1:0] idx;
    } slot_state_t;

    function automatic logic legacy_pass(legacy_pol_e pol, frame_t f);
        logic r;
        case (pol)
            POL_ALL:    r = 1'b1;
            POL_EXT:    r = f.ok && f.ext && f.hit && f.ext_en;
            POL_STD:    r = f.ok && !f.ext && f.hit && !f.ext_en;
            default:    r = f.ok && f.hit && (f.ext_en == f.ext);
        endcase
        return r;
    endfunction

    function automatic logic enhanced_pass(logic pol_bit, frame_t f);
        return pol_bit ? 1'b1 : (f.ok && f.hit);
    endfunction

endpackage

// File: rtl/canrx_accept.sv
module canrx_accept
    import canrx_slot_pkg::*;
(
    input  logic             done_i,
    input  logic             enh_i,
    input  logic [POL_W-1:0] pol_i,
    input  frame_t           frm_i,
    output logic             pass_o
);
    logic leg_ok;
    logic enh_ok;

    always_comb begin
        leg_ok = legacy_pass(legacy_pol_e'(pol_i), frm_i);
        enh_ok = enhanced_pass(pol_i[POL_W-1], frm_i);
        pass_o = done_i && (enh_i ? enh_ok : leg_ok);
    end
endmodule

// File: rtl/canrx_slot_state.sv
module canrx_slot_state
    import canrx_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enh_i,
    input  logic              pass_i,
    input  frame_t            frm_i,
    input  logic              wr_i,
    input  logic [POL_W:0]    wtop_i,
    output slot_state_t       st_o,
    output logic              load_o,
    output logic              ovf_o
);
    slot_state_t st_q;
    logic        take;
    logic        clr;

    assign take = pass_i && !st_q.full;
    assign clr  = wr_i && !wtop_i[POL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= '0;
            load_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            load_o <= take;
            ovf_o  <= pass_i && st_q.full;
            if (take) begin
                st_q.full <= 1'b1;
                st_q.rtr  <= frm_i.rtr;
                st_q.idx  <= frm_i.idx;
            end else if (clr) begin
                st_q.full <= 1'b0;
            end
            if (wr_i) begin
                if (enh_i) st_q.pol[POL_W-1] <= wtop_i[POL_W-1];
                else       st_q.pol          <= wtop_i[POL_W-1:0];
            end
        end
    end

    assign st_o = st_q;

    // R2: a load strobe is always accompanied by a full slot
    a_r2_load_marks_full: assert property (@(posedge clk) disable iff (rst)
        load_o |-> st_q.full);

    // R3: a full slot never produces a load on the next cycle
    a_r3_full_blocks_load: assert property (@(posedge clk) disable iff (rst)
        st_q.full |=> !load_o);

    // R3: overflow only follows a full slot
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> $past(st_q.full));

    // R4: the flag falls only after a clearing CPU write
    a_r4_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.full) |-> $past(wr_i && !wtop_i[POL_W]));

    // R12: captured status holds between loads
    a_r12_status_held: assert property (@(posedge clk) disable iff (rst)
        !load_o |-> ($stable(st_q.rtr) && $stable(st_q.idx)));
endmodule

// File: rtl/canrx_csr_view.sv
module canrx_csr_view
    import canrx_slot_pkg::*;
(
    input  logic              enh_i,
    input  slot_state_t       st_i,
    output logic [CSR_W-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        rdata_o[FULL_BIT]  = st_i.full;
        rdata_o[POLHI_BIT] = st_i.pol[POL_W-1];
        if (enh_i) begin
            rdata_o[POLLO_BIT]    = st_i.rtr;
            rdata_o[FIDX_W-1:0]   = st_i.idx;
        end else begin
            rdata_o[POLLO_BIT]    = st_i.pol[0];
            rdata_o[LIDX_W]       = st_i.rtr;
            rdata_o[LIDX_W-1:0]   = st_i.idx[LIDX_W-1:0];
        end
    end
endmodule

// File: rtl/canrx_slot_ctrl.sv
module canrx_slot_ctrl
    import canrx_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enh_i,
    input  logic              frm_done_i,
    input  logic              frm_ok_i,
    input  logic              frm_ext_i,
    input  logic              frm_rtr_i,
    input  logic              flt_hit_i,
    input  logic [FIDX_W-1:0] flt_idx_i,
    input  logic              flt_ext_en_i,
    input  logic              reg_wr_i,
    input  logic [CSR_W-1:0]  reg_wdata_i,
    output logic [CSR_W-1:0]  reg_rdata_o,
    output logic              load_o,
    output logic              ovf_o
);
    frame_t      frm;
    slot_state_t st;
    logic        pass;
    logic        unused_wlow;

    assign frm = '{ok: frm_ok_i, ext: frm_ext_i, rtr: frm_rtr_i,
                   hit: flt_hit_i, ext_en: flt_ext_en_i, idx: flt_idx_i};

    // low write bits address read-only fields
    assign unused_wlow = ^reg_wdata_i[POLLO_BIT-1:0];

    canrx_accept u_accept (
        .done_i (frm_done_i),
        .enh_i  (enh_i),
        .pol_i  (st.pol),
        .frm_i  (frm),
        .pass_o (pass)
    );

    canrx_slot_state u_state (
        .clk    (clk),
        .rst    (rst),
        .enh_i  (enh_i),
        .pass_i (pass),
        .frm_i  (frm),
        .wr_i   (reg_wr_i),
        .wtop_i (reg_wdata_i[FULL_BIT:POLLO_BIT]),
        .st_o   (st),
        .load_o (load_o),
        .ovf_o  (ovf_o)
    );

    canrx_csr_view u_view (
        .enh_i   (enh_i),
        .st_i    (st),
        .rdata_o (reg_rdata_o)
    );
endmodule

// File: tb/sim_canrx_slot_ctrl.sv
`timescale 1ns/1ps
module sim_canrx_slot_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enh = 1'b0;
    logic done = 1'b0, ok = 1'b0, ext = 1'b0, rtr = 1'b0, hit = 1'b0, een = 1'b0;
    logic [4:0] idx = '0;
    logic wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic load, ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    canrx_slot_ctrl u0 (
        .clk(clk), .rst(rst), .enh_i(enh), .frm_done_i(done), .frm_ok_i(ok),
        .frm_ext_i(ext), .frm_rtr_i(rtr), .flt_hit_i(hit), .flt_idx_i(idx),
        .flt_ext_en_i(een), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .load_o(load), .ovf_o(ovf)
    );

    // ---------------- behavioural reference ----------------
    bit m_full, m_rtr, m_load, m_ovf;
    int m_pol;
    int m_idx;

    function automatic bit ref_pass(bit e, int pol, bit o, bit x, bit h, bit en);
        if (e) return (pol >= 2) ? 1'b1 : (o && h);
        if (pol == 3) return 1'b1;
        if (pol == 2) return o && x && h && en;
        if (pol == 1) return o && !x && h && !en;
        return o && h && (en == x);
    endfunction

    function automatic logic [7:0] ref_byte(bit e);
        int v;
        v = m_full ? 128 : 0;
        if (e) v += (m_pol / 2) * 64 + (m_rtr ? 32 : 0) + m_idx;
        else   v += m_pol * 32 + (m_rtr ? 8 : 0) + (m_idx % 8);
        return v[7:0];
    endfunction

    always @(posedge clk) begin
        bit p;
        if (rst) begin
            m_full <= 0; m_pol <= 0; m_rtr <= 0; m_idx <= 0; m_load <= 0; m_ovf <= 0;
        end else begin
            p = done && ref_pass(enh, m_pol, ok, ext, hit, een);
            m_load <= p && !m_full;
            m_ovf  <= p && m_full;
            if (p && !m_full) begin
                m_full <= 1; m_rtr <= rtr; m_idx <= idx;
            end else if (wr && !wdata[7]) begin
                m_full <= 0;
            end
            if (wr) begin
                if (enh) m_pol <= (wdata[6] ? 2 : 0) + (m_pol % 2);
                else     m_pol <= wdata[6] * 2 + wdata[5];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks += 3;
            if (load !== m_load) begin
                errors++; $display("FAIL %s load_o actual=%b expected=%b", cur_req, load, m_load);
            end
            if (ovf !== m_ovf) begin
                errors++; $display("FAIL %s ovf_o actual=%b expected=%b", cur_req, ovf, m_ovf);
            end
            if (rdata !== ref_byte(enh)) begin
                errors++; $display("FAIL %s status actual=%h expected=%h", cur_req, rdata, ref_byte(enh));
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic frame(bit o, bit x, bit r, bit h, bit en, logic [4:0] i);
        done = 1; ok = o; ext = x; rtr = r; hit = h; een = en; idx = i;
        @(negedge clk);
        done = 0; ok = 0; ext = 0; rtr = 0; hit = 0; een = 0; idx = '0;
    endtask

    task automatic cpu_wr(logic [7:0] d);
        wr = 1; wdata = d;
        @(negedge clk);
        wr = 0; wdata = '0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 status", rdata, 8'h00);
        chk("R1 strobes", {6'b0, load, ovf}, 8'h00);

        // legacy policy 00, std frame, filter ext-en 0
        cur_req = "R2";
        frame(1, 0, 1, 1, 0, 5'd5);
        chk("R2 load pulse", {7'b0, load}, 8'h01);
        chk("R10 legacy layout", rdata, 8'h8D);
        idle();
        chk("R2 load one cycle", {7'b0, load}, 8'h00);

        cur_req = "R3";
        frame(1, 0, 0, 1, 0, 5'd2);
        chk("R3 overflow", {6'b0, load, ovf}, 8'h01);
        chk("R3 status kept", rdata, 8'h8D);
        idle();

        cur_req = "R4";
        cpu_wr(8'h6F);
        chk("R11 ro fields / R4 clear", rdata, 8'h6D);
        cpu_wr(8'hE0);
        chk("R4 write 1 no set", rdata, 8'h6D);

        cur_req = "R5";
        frame(0, 1, 0, 0, 0, 5'd3);
        chk("R5 accept errored", {7'b0, load}, 8'h01);
        chk("R5 status", rdata, 8'hE3);
        cpu_wr(8'h40);
        chk("R10 policy write", rdata, 8'h43);

        cur_req = "R6";
        frame(1, 0, 0, 1, 0, 5'd1);
        chk("R6 reject std", {7'b0, load}, 8'h00);
        frame(1, 1, 0, 1, 0, 5'd1);
        chk("R6 reject ext-en 0", {7'b0, load}, 8'h00);
        frame(0, 1, 0, 1, 1, 5'd1);
        chk("R6 reject errored", {7'b0, load}, 8'h00);
        frame(1, 1, 0, 1, 1, 5'd6);
        chk("R6 accept ext", rdata, 8'hC6);
        cpu_wr(8'h20);
        chk("R6 cleared", rdata, 8'h26);

        cur_req = "R7";
        frame(1, 1, 0, 1, 1, 5'd4);
        chk("R7 reject ext", {7'b0, load}, 8'h00);
        frame(1, 0, 1, 0, 0, 5'd4);
        chk("R7 reject no hit", {7'b0, load}, 8'h00);
        frame(1, 0, 1, 1, 0, 5'd1);
        chk("R7 accept std", rdata, 8'hA9);
        cpu_wr(8'h00);

        cur_req = "R8";
        frame(1, 1, 0, 1, 0, 5'd7);
        chk("R8 reject mismatch ext", {7'b0, load}, 8'h00);
        frame(1, 0, 0, 1, 1, 5'd7);
        chk("R8 reject mismatch std", {7'b0, load}, 8'h00);
        frame(1, 0, 0, 0, 0, 5'd7);
        chk("R8 reject no hit", {7'b0, load}, 8'h00);
        frame(1, 1, 0, 1, 1, 5'd7);
        chk("R8 accept ext match", rdata, 8'h87);

        cur_req = "R11";
        enh = 1;
        idle();
        chk("R11 enhanced view", rdata, 8'h87);
        cpu_wr(8'h00);
        cpu_wr(8'h7F);
        chk("R11 only policy bit", rdata, 8'h47);

        cur_req = "R9";
        frame(0, 0, 1, 0, 0, 5'h1A);
        chk("R9 accept all", rdata, 8'hFA);
        cur_req = "R10";
        enh = 0;
        idle();
        chk("R10 relayout", rdata, 8'hCA);
        enh = 1;
        cur_req = "R9";
        cpu_wr(8'h00);
        chk("R9 clear", rdata, 8'h3A);
        frame(0, 0, 0, 1, 0, 5'h11);
        chk("R9 reject errored", {7'b0, load}, 8'h00);
        frame(1, 1, 0, 0, 1, 5'h11);
        chk("R9 reject no hit", {7'b0, load}, 8'h00);
        frame(1, 1, 0, 1, 0, 5'h13);
        chk("R9 accept filter", rdata, 8'h93);

        // same-cycle clear and frame while full: frame sees full
        cur_req = "R4";
        wr = 1; wdata = 8'h00;
        frame(1, 0, 1, 1, 0, 5'h05);
        wr = 0;
        chk("R4 overflow on clear edge", {6'b0, load, ovf}, 8'h01);
        chk("R12 status kept", rdata, 8'h13);
        // same-cycle clear and frame while empty: load wins
        cur_req = "R12";
        wr = 1; wdata = 8'h00;
        frame(1, 0, 1, 1, 0, 5'h05);
        wr = 0;
        chk("R12 capture", rdata, 8'hA5);
        repeat (3) idle();
        chk("R12 held", rdata, 8'hA5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule